// File: doc/BRIEF.md
# Framed Serial Register-Write Decoder

This block sits behind a UART receiver and watches its byte stream for command packets. A packet opens with a fixed five-byte start pattern. Any number of two-byte words follows, and a single 0x7E byte closes it. Every word holds a 4-bit register address and an 8-bit data value, plus check bits that are the complements of two data bits. The decoder removes the framing and validates each word. For a good word it produces a one-clock register write with address and data. A malformed word produces a one-clock error pulse and no write.

The check bits always make bits 6 and 5 of each payload byte differ. The framing byte 0x7E therefore never appears inside a well-formed word, and the parser finds frame boundaries without byte stuffing. Bytes arrive one per clock at most, qualified by a valid strobe. Any number of idle clocks may fall between bytes.

Top module: `cmdlink_decoder`

## Requirements
- R1: After reset, `wr_en` and `bad_word` are low, `wr_addr` and `wr_data` are zero, and the parser is searching for a start pattern.
- R2: A frame begins only after the bytes 0x40, 0x4C, 0x44, 0x53, 0x7E are received in that order. Bytes received outside a frame never cause a write or an error.
- R3: If a byte breaks the start pattern, matching starts over. That same byte is tested again as a possible first byte 0x40, so 0x40 0x40 0x4C 0x44 0x53 0x7E opens a frame.
- R4: A word arrives high byte first, as word[15:8] and then word[7:0]. The address is word[11:8]. Data bits 5:0 are word[5:0], and data bits 7:6 are word[13:12].
- R5: A word is valid only when word[15] and word[7] are 0, word[6] equals the inverse of word[5], and word[14] equals the inverse of word[13]. For a word that fails, `bad_word` pulses and `wr_en` stays low.
- R6: All words of one frame are applied in arrival order, one write (or error) per word.
- R7: A 0x7E byte in the position of a word's high byte ends the frame. After that, bytes are ignored until a new start pattern arrives.
- R8: `wr_en` and `bad_word` go high for exactly one clock, in the clock after the word's low byte is accepted. `wr_addr` and `wr_data` change only together with a write and hold their values otherwise.
- R9: Bytes presented while `rx_valid` is low have no effect, whatever their value.
- R10: A 0x7E byte in the position of a word's low byte is treated as a malformed word. It produces `bad_word`, and the frame continues.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_valid | input | 1 | Byte strobe from the receiver |
| rx_byte | input | 8 | Received byte, valid when `rx_valid` is high |
| wr_en | output | 1 | One-clock register write strobe |
| wr_addr | output | 4 | Register address of the last write |
| wr_data | output | 8 | Data of the last write |
| bad_word | output | 1 | One-clock pulse for a rejected word |

## Verification
The decoder is driven with several kinds of input. First come words with no start pattern at all, then clean frames carrying one or several words. Start patterns with a false start show whether restart re-tests the breaking byte. Four word corruptions each break a different check bit and show that every rule is enforced on its own. Frames that end and then receive more words separate the end marker from an ordinary byte, and a 0x7E in the low-byte position shows how that case is treated. Gaps with `rx_valid` low, some carrying 0x7E, confirm that only strobed bytes count. A behavioural model is compared with the outputs on every clock.

// File: rtl/cmdlink_pkg.sv
package cmdlink_pkg;

  localparam int BYTE_W  = 8;
  localparam int WORD_W  = 16;
  localparam int ADDR_W  = 4;
  localparam int DATA_W  = 8;
  localparam int HDR_LEN = 5;
  localparam int HDR_IW  = $clog2(HDR_LEN);
  localparam logic [BYTE_W-1:0] END_BYTE = 8'h7E;

  typedef enum logic [1:0] {
    ST_HUNT  = 2'd0,
    ST_HIGH  = 2'd1,
    ST_LOW   = 2'd2
  } parse_st_t;

  function automatic logic [BYTE_W-1:0] hdr_byte(input logic [HDR_IW-1:0] k);
    case (k)
      3'd0:    hdr_byte = 8'h40;
      3'd1:    hdr_byte = 8'h4C;
      3'd2:    hdr_byte = 8'h44;
      3'd3:    hdr_byte = 8'h53;
      default: hdr_byte = END_BYTE;
    endcase
  endfunction

  function automatic logic word_ok(input logic [WORD_W-1:0] w);
    word_ok = !w[15] && !w[7] && (w[6] != w[5]) && (w[14] != w[13]);
  endfunction

  function automatic logic [ADDR_W-1:0] word_addr(input logic [WORD_W-1:0] w);
    word_addr = w[11:8];
  endfunction

  function automatic logic [DATA_W-1:0] word_data(input logic [WORD_W-1:0] w);
    word_data = {w[13:12], w[5:0]};
  endfunction

endpackage

// File: rtl/cmdlink_hunter.sv
module cmdlink_hunter
  import cmdlink_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  logic [BYTE_W-1:0] byte_in,
  output logic              hdr_found
);

  logic [HDR_IW-1:0] idx_q;
  logic              match;
  logic              last;

  assign match     = (byte_in == hdr_byte(idx_q));
  assign last      = (idx_q == HDR_IW'(HDR_LEN - 1));
  assign hdr_found = take && match && last;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx_q <= '0;
    end else if (take) begin
      if (match) begin
        idx_q <= last ? '0 : idx_q + 1'b1;
      end else if (byte_in == hdr_byte('0)) begin
        idx_q <= HDR_IW'(1);
      end else begin
        idx_q <= '0;
      end
    end
  end

endmodule

// File: rtl/cmdlink_framer.sv
module cmdlink_framer
  import cmdlink_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_valid,
  input  logic [BYTE_W-1:0] rx_byte,
  input  logic              hdr_found,
  output logic              hunting,
  output logic              await_hi,
  output logic              word_done,
  output logic [WORD_W-1:0] word
);

  parse_st_t         st_q;
  logic [BYTE_W-1:0] hi_q;

  assign hunting   = (st_q == ST_HUNT);
  assign await_hi  = (st_q == ST_HIGH);
  assign word_done = rx_valid && (st_q == ST_LOW);
  assign word      = {hi_q, rx_byte};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q <= ST_HUNT;
      hi_q <= '0;
    end else if (rx_valid) begin
      case (st_q)
        ST_HUNT: if (hdr_found) st_q <= ST_HIGH;
        ST_HIGH: begin
          if (rx_byte == END_BYTE) begin
            st_q <= ST_HUNT;
          end else begin
            hi_q <= rx_byte;
            st_q <= ST_LOW;
          end
        end
        ST_LOW:  st_q <= ST_HIGH;
        default: st_q <= ST_HUNT;
      endcase
    end
  end

endmodule

// File: rtl/cmdlink_wordout.sv
module cmdlink_wordout
  import cmdlink_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              word_done,
  input  logic [WORD_W-1:0] word,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic              bad_word
);

  logic good;
  assign good = word_ok(word);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_en    <= 1'b0;
      bad_word <= 1'b0;
      wr_addr  <= '0;
      wr_data  <= '0;
    end else begin
      wr_en    <= word_done && good;
      bad_word <= word_done && !good;
      if (word_done && good) begin
        wr_addr <= word_addr(word);
        wr_data <= word_data(word);
      end
    end
  end

endmodule

// File: rtl/cmdlink_decoder.sv
module cmdlink_decoder
  import cmdlink_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_valid,
  input  logic [7:0]        rx_byte,
  output logic              wr_en,
  output logic [3:0]        wr_addr,
  output logic [7:0]        wr_data,
  output logic              bad_word
);

  logic              hunting;
  logic              await_hi;
  logic              hdr_found;
  logic              word_done;
  logic [WORD_W-1:0] word;

  cmdlink_hunter u_hunt (
    .clk       (clk),
    .rst_n     (rst_n),
    .take      (rx_valid && hunting),
    .byte_in   (rx_byte),
    .hdr_found (hdr_found)
  );

  cmdlink_framer u_frame (
    .clk       (clk),
    .rst_n     (rst_n),
    .rx_valid  (rx_valid),
    .rx_byte   (rx_byte),
    .hdr_found (hdr_found),
    .hunting   (hunting),
    .await_hi  (await_hi),
    .word_done (word_done),
    .word      (word)
  );

  cmdlink_wordout u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .word_done (word_done),
    .word      (word),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .bad_word  (bad_word)
  );

endmodule

// File: rtl/cmdlink_decoder_chk.sv
module cmdlink_decoder_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       rx_valid,
  input logic [7:0] rx_byte,
  input logic       hunting,
  input logic       await_hi,
  input logic       hdr_found,
  input logic       word_done,
  input logic       wr_en,
  input logic [3:0] wr_addr,
  input logic [7:0] wr_data,
  input logic       bad_word
);

  p_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && bad_word));

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |-> ($stable(wr_addr) && $stable(wr_data)));

  p_from_word_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en || bad_word) |-> $past(word_done));

  p_hdr_tail_r2: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_found |-> (rx_valid && rx_byte == 8'h7E && hunting));

  p_enter_r2: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_found |=> await_hi);

  p_end_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (await_hi && rx_valid && rx_byte == 8'h7E) |=> hunting);

  p_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_valid |=> (!wr_en && !bad_word));

endmodule

bind cmdlink_decoder cmdlink_decoder_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .rx_valid  (rx_valid),
  .rx_byte   (rx_byte),
  .hunting   (hunting),
  .await_hi  (await_hi),
  .hdr_found (hdr_found),
  .word_done (word_done),
  .wr_en     (wr_en),
  .wr_addr   (wr_addr),
  .wr_data   (wr_data),
  .bad_word  (bad_word)
);

// File: tb/sim_cmdlink_decoder.sv
`timescale 1ns/1ps
module sim_cmdlink_decoder;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rx_valid = 1'b0;
  logic [7:0] rx_byte = 8'h00;
  logic       wr_en;
  logic [3:0] wr_addr;
  logic [7:0] wr_data;
  logic       bad_word;

  always #2.5 clk = ~clk;

  cmdlink_decoder u0 (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_byte(rx_byte),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .bad_word(bad_word)
  );

  int tests = 0;
  int fails = 0;
  int cycles = 0;
  bit done = 0;

  // behavioural reference model
  int hdr[5] = '{8'h40, 8'h4C, 8'h44, 8'h53, 8'h7E};
  int m_mode = 0;   // 0 searching, 1 expect high byte, 2 expect low byte
  int m_pos  = 0;
  int m_hi   = 0;
  bit e_wr = 0, e_bad = 0;
  int e_addr = 0, e_data = 0;

  int n_wr = 0, n_bad = 0;
  int obs_q[$];

  function automatic int enc(int a, int d);
    return (d & 'h3f) | ((d & 'hc0) << 6) | ((a & 'hf) << 8)
         | ((~d & 'h20) << 1) | ((~d & 'h80) << 7);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_mode = 0; m_pos = 0; m_hi = 0;
      e_wr = 0; e_bad = 0; e_addr = 0; e_data = 0;
    end else begin
      e_wr = 0; e_bad = 0;
      if (rx_valid) begin
        if (m_mode == 0) begin
          if (int'(rx_byte) == hdr[m_pos]) begin
            m_pos++;
            if (m_pos == 5) begin m_pos = 0; m_mode = 1; end
          end else begin
            m_pos = (rx_byte == 8'h40) ? 1 : 0;
          end
        end else if (m_mode == 1) begin
          if (rx_byte == 8'h7E) m_mode = 0;
          else begin m_hi = int'(rx_byte); m_mode = 2; end
        end else begin
          int w, a, d;
          w = (m_hi << 8) | int'(rx_byte);
          a = (w >> 8) & 'hf;
          d = (w & 'h3f) | ((w >> 6) & 'hc0);
          if (enc(a, d) == w) begin
            e_wr = 1; e_addr = a; e_data = d;
          end else e_bad = 1;
          m_mode = 1;
        end
      end
    end
  end

  task automatic chk(string req, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R8 wr_en", int'(wr_en), int'(e_wr));
      chk("R5 bad_word", int'(bad_word), int'(e_bad));
      chk("R4 wr_addr", int'(wr_addr), e_addr);
      chk("R4 wr_data", int'(wr_data), e_data);
      if (wr_en) begin n_wr++; obs_q.push_back({wr_addr, wr_data}); end
      if (bad_word) n_bad++;
    end
  end

  task automatic send(int b);
    @(negedge clk); rx_valid = 1'b1; rx_byte = 8'(b);
  endtask
  task automatic idle(int n);
    repeat (n) begin @(negedge clk); rx_valid = 1'b0; end
  endtask
  task automatic send_word(int w);
    send((w >> 8) & 'hff); send(w & 'hff);
  endtask
  task automatic header();
    for (int i = 0; i < 5; i++) send(hdr[i]);
  endtask
  task automatic clear();
    idle(3); n_wr = 0; n_bad = 0; obs_q.delete();
  endtask

  task automatic finish_run();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      tests++; fails++;
      $display("FAIL watchdog actual=%0d expected=<150000", cycles);
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 wr_en", int'(wr_en), 0);
    chk("R1 bad_word", int'(bad_word), 0);
    chk("R1 addr", int'(wr_addr), 0);
    chk("R1 data", int'(wr_data), 0);

    // R2 words with no start pattern are ignored
    clear();
    send_word(enc(3, 'h11)); send_word(enc(5, 'h22)); send('h7E);
    clear();
    chk("R2 no frame writes", n_wr + n_bad, 0);
    header(); send_word(enc(3, 'hA5)); send('h7E);
    idle(3);
    chk("R2 one write", n_wr, 1);
    chk("R4 fields", obs_q.size() ? obs_q[0] : -1, ('h3 << 8) | 'hA5);

    // R3 false starts
    clear();
    send('h40); header(); send_word(enc(9, 'h3C)); send('h7E);
    send('h40); send('h4C); header(); send_word(enc(1, 'hFF)); send('h7E);
    idle(3);
    chk("R3 restart writes", n_wr, 2);

    // R6 several words in order
    clear();
    header();
    for (int i = 0; i < 6; i++) send_word(enc(i * 3, 'h17 * i + 'h40));
    send('h7E);
    idle(3);
    chk("R6 count", n_wr, 6);
    for (int i = 0; i < 6; i++)
      chk("R6 order", obs_q.size() > i ? obs_q[i] : -1,
          (((i * 3) & 'hf) << 8) | (('h17 * i + 'h40) & 'hff));

    // R5 corrupted words
    clear();
    header();
    send_word(enc(2, 'h5A) ^ 'h0040);
    send_word(enc(2, 'h5A) | 'h8000);
    send_word(enc(2, 'h5A) | 'h0080);
    send_word(enc(2, 'h5A) ^ 'h4000);
    send_word(enc(7, 'h81));
    send('h7E);
    idle(3);
    chk("R5 errors", n_bad, 4);
    chk("R5 writes", n_wr, 1);

    // R7 end marker, then orphan word
    clear();
    header(); send_word(enc(4, 'h66)); send('h7E); send_word(enc(6, 'h99));
    idle(3);
    chk("R7 writes", n_wr, 1);
    chk("R7 errors", n_bad, 0);

    // R9 gaps, with 0x7E on the idle bus
    clear();
    for (int i = 0; i < 5; i++) begin
      send(hdr[i]); @(negedge clk); rx_valid = 1'b0; rx_byte = 8'h7E;
    end
    send(enc(11, 'h2D) >> 8); idle(2); rx_byte = 8'h7E; idle(1);
    send(enc(11, 'h2D) & 'hff); idle(2);
    send('h7E);
    idle(3);
    chk("R9 gapped write", n_wr, 1);
    chk("R9 value", obs_q.size() ? obs_q[0] : -1, ('hB << 8) | 'h2D);

    // R10 end marker in low byte slot
    clear();
    header(); send(enc(8, 'h10) >> 8); send('h7E); send_word(enc(8, 'h10)); send('h7E);
    idle(3);
    chk("R10 error", n_bad, 1);
    chk("R10 frame continues", n_wr, 1);

    // R8 back-to-back writes and holding of address/data
    clear();
    header(); send_word(enc(12, 'hC3)); send_word(enc(13, 'h3C)); send('h7E);
    idle(10);
    chk("R8 pulses", n_wr, 2);
    chk("R8 hold addr", int'(wr_addr), 13);
    chk("R8 hold data", int'(wr_data), 'h3C);

    idle(2);
    finish_run();
  end

endmodule